// File: doc/BRIEF.md
# SCSI Controller Interrupt and Status Unit

This block holds the interrupt and status registers of a simple SCSI bus controller, together with the first control word of its DMA companion. A host reads and writes byte-wide registers at 4-byte spacing. Writes to the command register trigger flush, chip reset, bus reset or transfer-information actions. Transfer-complete and target-selection events come in from the rest of the controller. Each action leaves an interrupt reason, a status byte and a sequence step for the host. A pending flag in the DMA control word, ANDed with an enable bit in the same word, drives the single interrupt line.

The host acknowledges an interrupt by reading the interrupt-reason register. That read keeps only the terminal-count bit of the status byte and drops the pending flag. Read data is a plain multiplexer on the current address, so the host sees a register's value before any clear that its own read causes. Bus phases, buffered data movement and DMA memory traffic are handled elsewhere.

Top module: `scsi_irq_unit`

## Requirements
- R1: The register index is bits [5:2] of the host byte address. Address bits [1:0] and all bits above bit 5 are ignored.
- R2: After reset, all sixteen readable registers read 0x00, `irq` is low and `dma_ctrl` reads 0xA0000000. The version byte 0xA0 sits in bits [31:24].
- R3: A host read of index 5 (interrupt reason) returns the reason unchanged. In the following cycle the status byte (index 4) keeps only bit 4 (terminal count, 0x10), `dma_ctrl` bit 0 (pending) is clear and `irq` is low.
- R4: `irq` is high exactly when `dma_ctrl` bit 0 (pending) and bit 4 (enable) are both set. A DMA write with bit 4 clear drops `irq` in the next cycle and leaves pending set.
- R5: Writing command 0x01 (flush) to index 3 sets the reason to 0x08 (function complete) and the sequence step (index 6) to 0. It does not set pending.
- R6: Writing command 0x03 (bus reset) to index 3 sets the reason to 0x80. Pending is set only when bit 6 of the write-only configuration register (index 8) is clear.
- R7: Writing command 0x02 (chip reset) to index 3, or a DMA write with bit 7 set, returns the whole unit to the state of R2, including the configuration register.
- R8: A write to index 11 stores only the bits in mask 0x15. Writes to indices 12 to 15 store the full byte. Writes to indices 0-2, 4-7, 9 and 10 leave every readback unchanged. Index 8 always reads 0x00.
- R9: A `xfer_done` pulse or command 0x10 (transfer information) sets status 0x93, reason 0x10, sequence step 0 and pending. Status bit 7 means interrupt, bit 4 terminal count, and bits [2:0] = 3 the status phase.
- R10: A `sel_req` whose `sel_target` is 4 or more, or names a target whose `tgt_present` bit is clear, sets status 0x80, reason 0x20 (disconnect), sequence step 0 and pending.
- R11: A `sel_req` to a present target below 4 sets status 0x91 (interrupt, terminal count, data-in phase 1), reason 0x18, sequence step 0x04 and pending.
- R12: An event that arrives in the same cycle as an acknowledging read wins. Pending stays set and the status byte is the one the event writes.
- R13: A DMA write stores bits [23:1] except bit 7. Bit 0 of the write has no effect, and bits [31:24] always read 0xA0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_rd | input | 1 | Host read strobe for one cycle |
| host_wr | input | 1 | Host write strobe for one cycle |
| host_addr | input | 8 | Host byte address |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Byte at the addressed register |
| dma_wr | input | 1 | DMA control word write strobe |
| dma_wdata | input | 24 | Writable low bits of the DMA control word |
| dma_ctrl | output | 32 | DMA control word readback |
| xfer_done | input | 1 | Transfer-complete event pulse |
| sel_req | input | 1 | Target-selection event pulse |
| sel_target | input | 3 | Target ID of the selection |
| tgt_present | input | 4 | One bit per attached target |
| irq | output | 1 | Interrupt request |

## Verification
The checker checks several rules on every cycle. A quiet acknowledge must drop `irq` and keep only terminal count. Flush must clear the sequence step. A masked bus reset must not raise pending. A failed selection must report a disconnect. A DMA-side reset must restore the version-only word, and an event must beat a same-cycle acknowledge. Only the bench scenarios can show the exact status, reason and step bytes of each event. They also cover address aliasing through ignored address bits, the write masks, and that the configuration register is cleared by a chip reset so that bus resets interrupt again.

// File: rtl/sirq_pkg.sv
// Package: shared constants and the decoded-command type for the
// interrupt and status unit. Assumes byte-wide registers, 16 of them.
package sirq_pkg;
    localparam int DATA_W    = 8;
    localparam int REG_COUNT = 16;
    localparam int IDX_W     = $clog2(REG_COUNT);
    localparam int IDX_LSB   = 2;

    // register indices whose position other logic depends on
    localparam logic [IDX_W-1:0] IDX_CMD    = 4'd3;
    localparam logic [IDX_W-1:0] IDX_STATUS = 4'd4;
    localparam logic [IDX_W-1:0] IDX_REASON = 4'd5;
    localparam logic [IDX_W-1:0] IDX_STEP   = 4'd6;
    localparam logic [IDX_W-1:0] IDX_CFG    = 4'd8;
    localparam logic [IDX_W-1:0] IDX_MASKED = 4'd11;
    localparam int               USER_BASE  = 12;
    localparam int               USER_COUNT = REG_COUNT - USER_BASE;

    localparam logic [DATA_W-1:0] OP_FLUSH     = 8'h01;
    localparam logic [DATA_W-1:0] OP_CHIP_RST  = 8'h02;
    localparam logic [DATA_W-1:0] OP_BUS_RST   = 8'h03;
    localparam logic [DATA_W-1:0] OP_XFER_INFO = 8'h10;

    localparam logic [DATA_W-1:0] WHY_FUNC_DONE  = 8'h08;
    localparam logic [DATA_W-1:0] WHY_BUS_SVC    = 8'h10;
    localparam logic [DATA_W-1:0] WHY_DISCONNECT = 8'h20;
    localparam logic [DATA_W-1:0] WHY_BUS_RESET  = 8'h80;

    localparam logic [DATA_W-1:0] STS_IRQ      = 8'h80;
    localparam logic [DATA_W-1:0] STS_TCOUNT   = 8'h10;
    localparam logic [DATA_W-1:0] PHASE_DIN    = 8'h01;
    localparam logic [DATA_W-1:0] PHASE_STATUS = 8'h03;
    localparam logic [DATA_W-1:0] STEP_DONE    = 8'h04;

    localparam logic [DATA_W-1:0] MASK_IDX11   = 8'h15;
    localparam int                CFG_MUTE_BIT = 6;

    localparam int DMA_PEND_BIT = 0;
    localparam int DMA_EN_BIT   = 4;
    localparam int DMA_RST_BIT  = 7;

    typedef struct packed {
        logic flush;
        logic chip_rst;
        logic bus_rst;
        logic xfer_info;
    } sirq_cmd_t;
endpackage

// File: rtl/sirq_host_decode.sv
// Host decoder: turns the byte address into a register index, one write
// enable per register, the decoded command strobes and the acknowledge
// (read of the reason register). Assumes rd and wr are never both high.
module sirq_host_decode
    import sirq_pkg::*;
#(
    parameter int HOST_ADDR_W = 8
) (
    input  logic                   host_rd,
    input  logic                   host_wr,
    input  logic [HOST_ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0]      host_wdata,
    output logic [IDX_W-1:0]       idx,
    output logic [REG_COUNT-1:0]   reg_we,
    output sirq_cmd_t              cmd,
    output logic                   ack
);
    localparam int IDX_MSB = IDX_LSB + IDX_W - 1;

    logic unused_addr_bits;
    assign unused_addr_bits = ^{host_addr[HOST_ADDR_W-1:IDX_MSB+1], host_addr[IDX_LSB-1:0]};

    // index from the word-spaced address
    assign idx = host_addr[IDX_MSB:IDX_LSB];

    // one write enable per register
    for (genvar g = 0; g < REG_COUNT; g++) begin : g_we
        assign reg_we[g] = host_wr && (idx == IDX_W'(g));
    end

    // command strobes from a write to the command register
    always_comb begin
        cmd.flush     = reg_we[IDX_CMD] && (host_wdata == OP_FLUSH);
        cmd.chip_rst  = reg_we[IDX_CMD] && (host_wdata == OP_CHIP_RST);
        cmd.bus_rst   = reg_we[IDX_CMD] && (host_wdata == OP_BUS_RST);
        cmd.xfer_info = reg_we[IDX_CMD] && (host_wdata == OP_XFER_INFO);
    end

    assign ack = host_rd && (idx == IDX_REASON);
endmodule

// File: rtl/sirq_regfile.sv
// Register file: status, reason and sequence-step registers updated by
// commands and events, plus the write-only configuration byte and the
// host-writable bytes. Assumes one host access per cycle; a later
// event in the same cycle overrides an earlier one.
module sirq_regfile
    import sirq_pkg::*;
#(
    parameter int NUM_TARGETS = 4,
    parameter int TGT_W       = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   soft_rst,
    input  logic [IDX_W-1:0]       idx,
    input  logic [REG_COUNT-1:0]   reg_we,
    input  logic [DATA_W-1:0]      host_wdata,
    input  sirq_cmd_t              cmd,
    input  logic                   ack,
    input  logic                   xfer_done,
    input  logic                   sel_req,
    input  logic [TGT_W-1:0]       sel_target,
    input  logic [NUM_TARGETS-1:0] tgt_present,
    output logic [DATA_W-1:0]      rdata,
    output logic                   set_pend,
    output logic [DATA_W-1:0]      status_o,
    output logic [DATA_W-1:0]      reason_o,
    output logic [DATA_W-1:0]      step_o
);
    localparam int TSEL_W = (NUM_TARGETS > 1) ? $clog2(NUM_TARGETS) : 1;

    logic [DATA_W-1:0] status_q, reason_q, step_q, cfg_q, masked_q;
    logic [DATA_W-1:0] user_q [USER_COUNT];
    logic              sel_ok, finish;

    // selection succeeds only for an in-range, present target
    assign sel_ok = (sel_target < TGT_W'(NUM_TARGETS)) &&
                    tgt_present[sel_target[TSEL_W-1:0]];
    assign finish = cmd.xfer_info || xfer_done;

    // status, reason and step updates; later statements take priority
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            status_q <= '0;
            reason_q <= '0;
            step_q   <= '0;
        end else begin
            if (ack)
                status_q <= status_q & STS_TCOUNT;
            if (cmd.flush) begin
                reason_q <= WHY_FUNC_DONE;
                step_q   <= '0;
            end
            if (cmd.bus_rst)
                reason_q <= WHY_BUS_RESET;
            if (finish) begin
                status_q <= STS_IRQ | STS_TCOUNT | PHASE_STATUS;
                reason_q <= WHY_BUS_SVC;
                step_q   <= '0;
            end
            if (sel_req && !sel_ok) begin
                status_q <= STS_IRQ;
                reason_q <= WHY_DISCONNECT;
                step_q   <= '0;
            end else if (sel_req) begin
                status_q <= STS_IRQ | STS_TCOUNT | PHASE_DIN;
                reason_q <= WHY_BUS_SVC | WHY_FUNC_DONE;
                step_q   <= STEP_DONE;
            end
        end
    end

    // host-writable bytes and the configuration byte
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            cfg_q    <= '0;
            masked_q <= '0;
            for (int i = 0; i < USER_COUNT; i++) user_q[i] <= '0;
        end else begin
            if (reg_we[IDX_CFG])    cfg_q    <= host_wdata;
            if (reg_we[IDX_MASKED]) masked_q <= host_wdata & MASK_IDX11;
            for (int i = 0; i < USER_COUNT; i++)
                if (reg_we[USER_BASE+i]) user_q[i] <= host_wdata;
        end
    end

    // pending-flag request toward the DMA control word
    assign set_pend = finish || sel_req || (cmd.bus_rst && !cfg_q[CFG_MUTE_BIT]);

    // read multiplexer on the current index
    always_comb begin
        rdata = '0;
        if (idx == IDX_STATUS)       rdata = status_q;
        else if (idx == IDX_REASON)  rdata = reason_q;
        else if (idx == IDX_STEP)    rdata = step_q;
        else if (idx == IDX_MASKED)  rdata = masked_q;
        else if (int'(idx) >= USER_BASE)
            rdata = user_q[int'(idx) - USER_BASE];
    end

    assign status_o = status_q;
    assign reason_o = reason_q;
    assign step_o   = step_q;
endmodule

// File: rtl/sirq_dma_ctrl.sv
// DMA control word: fixed version byte, writable control bits, the
// pending flag, and the gated interrupt output. Assumes the reset bit
// is a write-only trigger and the pending bit is set only by events.
module sirq_dma_ctrl
    import sirq_pkg::*;
#(
    parameter int                         DMA_W       = 32,
    parameter logic [DMA_W-DMA_W/4*3-1:0] DMA_VERSION = 8'hA0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   soft_rst,
    input  logic                   dma_wr,
    input  logic [DMA_W/4*3-1:0]   dma_wdata,
    input  logic                   set_pend,
    input  logic                   clr_pend,
    output logic                   dma_rst,
    output logic [DMA_W-1:0]       dma_ctrl,
    output logic                   irq
);
    localparam int LOW_W = DMA_W / 4 * 3;

    logic [LOW_W-1:1] ctl_q;
    logic             pend_q;
    logic             unused_wbit;

    assign unused_wbit = dma_wdata[DMA_PEND_BIT];
    assign dma_rst     = dma_wr && dma_wdata[DMA_RST_BIT];

    // writable control bits; the reset bit is never stored
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            ctl_q <= '0;
        end else if (dma_wr) begin
            ctl_q              <= dma_wdata[LOW_W-1:1];
            ctl_q[DMA_RST_BIT] <= 1'b0;
        end
    end

    // pending flag: an event wins over an acknowledge in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) pend_q <= 1'b0;
        else if (set_pend)      pend_q <= 1'b1;
        else if (clr_pend)      pend_q <= 1'b0;
    end

    assign dma_ctrl = {DMA_VERSION, ctl_q, pend_q};
    assign irq      = pend_q && ctl_q[DMA_EN_BIT];
endmodule

// File: rtl/scsi_irq_unit.sv
// Top: interrupt and status unit of a SCSI bus controller. Joins the
// host decoder, register file and DMA control word; a chip-reset
// command or a DMA reset write clears the whole unit in one cycle.
module scsi_irq_unit
    import sirq_pkg::*;
#(
    parameter int                         HOST_ADDR_W = 8,
    parameter int                         NUM_TARGETS = 4,
    parameter int                         TGT_W       = 3,
    parameter int                         DMA_W       = 32,
    parameter logic [DMA_W-DMA_W/4*3-1:0] DMA_VERSION = 8'hA0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   host_rd,
    input  logic                   host_wr,
    input  logic [HOST_ADDR_W-1:0] host_addr,
    input  logic [7:0]             host_wdata,
    output logic [7:0]             host_rdata,
    input  logic                   dma_wr,
    input  logic [DMA_W/4*3-1:0]   dma_wdata,
    output logic [DMA_W-1:0]       dma_ctrl,
    input  logic                   xfer_done,
    input  logic                   sel_req,
    input  logic [TGT_W-1:0]       sel_target,
    input  logic [NUM_TARGETS-1:0] tgt_present,
    output logic                   irq
);
    logic [IDX_W-1:0]     idx_w;
    logic [REG_COUNT-1:0] reg_we_w;
    sirq_cmd_t            cmd_w;
    logic                 ack_w, set_pend_w, dma_rst_w, soft_rst_w;
    logic [DATA_W-1:0]    status_w, reason_w, step_w;

    assign soft_rst_w = cmd_w.chip_rst || dma_rst_w;

    sirq_host_decode #(.HOST_ADDR_W(HOST_ADDR_W)) decode_i (
        .host_rd(host_rd), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .idx(idx_w), .reg_we(reg_we_w),
        .cmd(cmd_w), .ack(ack_w)
    );

    sirq_regfile #(.NUM_TARGETS(NUM_TARGETS), .TGT_W(TGT_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst_w), .idx(idx_w),
        .reg_we(reg_we_w), .host_wdata(host_wdata), .cmd(cmd_w), .ack(ack_w),
        .xfer_done(xfer_done), .sel_req(sel_req), .sel_target(sel_target),
        .tgt_present(tgt_present), .rdata(host_rdata), .set_pend(set_pend_w),
        .status_o(status_w), .reason_o(reason_w), .step_o(step_w)
    );

    sirq_dma_ctrl #(.DMA_W(DMA_W), .DMA_VERSION(DMA_VERSION)) dma_i (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst_w), .dma_wr(dma_wr),
        .dma_wdata(dma_wdata), .set_pend(set_pend_w), .clr_pend(ack_w),
        .dma_rst(dma_rst_w), .dma_ctrl(dma_ctrl), .irq(irq)
    );
endmodule

// File: rtl/scsi_irq_unit_chk.sv
// Checker for the interrupt and status unit, bound to the top. It
// recomputes host commands from the ports and watches the internal
// status, reason and step bytes. Assumes one host access per cycle.
module scsi_irq_unit_chk #(
    parameter int                         HOST_ADDR_W = 8,
    parameter int                         NUM_TARGETS = 4,
    parameter int                         TGT_W       = 3,
    parameter int                         DMA_W       = 32,
    parameter logic [DMA_W-DMA_W/4*3-1:0] DMA_VERSION = 8'hA0
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   host_rd,
    input logic                   host_wr,
    input logic [HOST_ADDR_W-1:0] host_addr,
    input logic [7:0]             host_wdata,
    input logic                   dma_wr,
    input logic [DMA_W/4*3-1:0]   dma_wdata,
    input logic [DMA_W-1:0]       dma_ctrl,
    input logic                   xfer_done,
    input logic                   sel_req,
    input logic [TGT_W-1:0]       sel_target,
    input logic                   irq,
    input logic [7:0]             status,
    input logic [7:0]             reason,
    input logic [7:0]             step
);
    logic [3:0] cidx;
    logic       c_ack, c_flush, c_busrst, no_evt;
    assign cidx     = host_addr[5:2];
    assign c_ack    = host_rd && !host_wr && cidx == 4'd5;
    assign c_flush  = host_wr && cidx == 4'd3 && host_wdata == 8'h01;
    assign c_busrst = host_wr && cidx == 4'd3 && host_wdata == 8'h03;
    assign no_evt   = !xfer_done && !sel_req && !dma_wr;

    p_ack_drops_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        c_ack && no_evt |=> !irq && !dma_ctrl[0]);
    p_ack_keeps_tc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        c_ack && no_evt |=> (status & 8'hEF) == 8'h00 && status[4] == $past(status[4]));
    p_irq_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dma_wr && !dma_wdata[4] |=> !irq);
    p_flush_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        c_flush && no_evt |=> step == 8'h00 && reason == 8'h08);
    p_busrst_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        c_busrst && no_evt && !dma_ctrl[0] && $past(host_wr && host_addr[5:2] == 4'd8 && host_wdata[6]) |=> !dma_ctrl[0]);
    p_dma_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dma_wr && dma_wdata[7] |=> dma_ctrl == {DMA_VERSION, {(DMA_W/4*3){1'b0}}} && status == 8'h00 && !irq);
    p_sel_fail_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sel_req && sel_target >= TGT_W'(NUM_TARGETS) && !dma_wr && !host_wr |=> reason == 8'h20 && step == 8'h00 && dma_ctrl[0]);
    p_evt_beats_ack_r12: assert property (@(posedge clk) disable iff (!rst_n)
        c_ack && xfer_done && !sel_req && !dma_wr |=> dma_ctrl[0] && status == 8'h93);
endmodule

bind scsi_irq_unit scsi_irq_unit_chk #(
    .HOST_ADDR_W(HOST_ADDR_W), .NUM_TARGETS(NUM_TARGETS), .TGT_W(TGT_W),
    .DMA_W(DMA_W), .DMA_VERSION(DMA_VERSION)
) chk_i (
    .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .dma_wr(dma_wr),
    .dma_wdata(dma_wdata), .dma_ctrl(dma_ctrl), .xfer_done(xfer_done),
    .sel_req(sel_req), .sel_target(sel_target), .irq(irq),
    .status(status_w), .reason(reason_w), .step(step_w)
);

// File: tb/scsi_irq_unit_tb_top.sv
// Bench: a vector table for register writes and readback, then directed
// scenarios for reset, events, commands, acknowledge and corner cases.
module scsi_irq_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_rd = 1'b0, host_wr = 1'b0;
    logic [7:0]  host_addr = '0, host_wdata = '0, host_rdata;
    logic        dma_wr = 1'b0;
    logic [23:0] dma_wdata = '0;
    logic [31:0] dma_ctrl;
    logic        xfer_done = 1'b0, sel_req = 1'b0, irq;
    logic [2:0]  sel_target = '0;
    logic [3:0]  tgt_present = 4'b0011;

    int  n_chk = 0, n_err = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    scsi_irq_unit dut_i (
        .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .dma_wr(dma_wr), .dma_wdata(dma_wdata), .dma_ctrl(dma_ctrl),
        .xfer_done(xfer_done), .sel_req(sel_req), .sel_target(sel_target),
        .tgt_present(tgt_present), .irq(irq)
    );

    // {write addr, write data, readback addr, expected byte}
    localparam logic [31:0] VEC [11] = '{
        32'h2CFF_2C15, 32'h30A5_30A5, 32'h343C_343C, 32'h3881_3881,
        32'h3C7E_3C7E, 32'hEC04_2C04, 32'h2D11_2F11, 32'h1CFF_1C00,
        32'h0055_0000, 32'h2433_2400, 32'h2000_2000
    };

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic host_write(logic [7:0] a, logic [7:0] d);
        @(negedge clk); host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk); host_wr = 1'b0;
    endtask

    task automatic host_read(logic [7:0] a, output logic [7:0] d);
        @(negedge clk); host_rd = 1'b1; host_addr = a; #1 d = host_rdata;
        @(negedge clk); host_rd = 1'b0;
    endtask

    task automatic peek(string tag, logic [7:0] a, logic [7:0] exp);
        host_addr = a; #1;
        check(tag, {24'h0, host_rdata}, {24'h0, exp});
    endtask

    task automatic dma_write(logic [23:0] d);
        @(negedge clk); dma_wr = 1'b1; dma_wdata = d;
        @(negedge clk); dma_wr = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk); xfer_done = 1'b1;
        @(negedge clk); xfer_done = 1'b0;
    endtask

    task automatic select(logic [2:0] t);
        @(negedge clk); sel_req = 1'b1; sel_target = t;
        @(negedge clk); sel_req = 1'b0;
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2 reset state
        for (int i = 0; i < 16; i++) peek("R2 reg", 8'(i * 4), 8'h00);
        check("R2 irq", {31'h0, irq}, 32'h0);
        check("R2 dma", dma_ctrl, 32'hA000_0000);

        // R8 and R1 write masks, ignored registers and address aliasing
        for (int v = 0; v < 11; v++) begin
            host_write(VEC[v][31:24], VEC[v][23:16]);
            peek("R8/R1 vector", VEC[v][15:8], VEC[v][7:0]);
        end

        // R13 DMA word writes
        dma_write(24'h000010);
        check("R13 enable", dma_ctrl, 32'hA000_0010);
        dma_write(24'h010111);
        check("R13 bit0 ignored", dma_ctrl, 32'hA001_0110);
        check("R13 no irq", {31'h0, irq}, 32'h0);
        dma_write(24'h000010);

        // R9 transfer complete
        pulse_done();
        peek("R9 status", 8'h10, 8'h93);
        peek("R9 reason", 8'h14, 8'h10);
        peek("R9 step", 8'h18, 8'h00);
        check("R9 irq", {31'h0, irq}, 32'h1);
        check("R9 pending", dma_ctrl, 32'hA000_0011);

        // R3 acknowledge
        host_read(8'h14, rd);
        check("R3 read value", {24'h0, rd}, 32'h10);
        peek("R3 status keeps tc", 8'h10, 8'h10);
        peek("R3 reason kept", 8'h14, 8'h10);
        check("R3 irq low", {31'h0, irq}, 32'h0);
        check("R3 pending clear", dma_ctrl, 32'hA000_0010);

        // R4 enable gating
        pulse_done();
        check("R4 irq up", {31'h0, irq}, 32'h1);
        dma_write(24'h000000);
        check("R4 irq gated", {31'h0, irq}, 32'h0);
        check("R4 pending kept", dma_ctrl, 32'hA000_0001);
        dma_write(24'h000010);
        check("R4 irq back", {31'h0, irq}, 32'h1);
        host_read(8'h14, rd);

        // R11 selection success
        select(3'd1);
        peek("R11 status", 8'h10, 8'h91);
        peek("R11 reason", 8'h14, 8'h18);
        peek("R11 step", 8'h18, 8'h04);
        check("R11 irq", {31'h0, irq}, 32'h1);
        host_read(8'h14, rd);

        // R5 flush
        host_write(8'h0C, 8'h01);
        peek("R5 reason", 8'h14, 8'h08);
        peek("R5 step", 8'h18, 8'h00);
        check("R5 no irq", {31'h0, irq}, 32'h0);

        // R10 selection failure: out of range, then absent
        select(3'd5);
        peek("R10 status", 8'h10, 8'h80);
        peek("R10 reason", 8'h14, 8'h20);
        check("R10 irq", {31'h0, irq}, 32'h1);
        host_read(8'h14, rd);
        peek("R10 ack status", 8'h10, 8'h00);
        select(3'd2);
        peek("R10 absent reason", 8'h14, 8'h20);
        peek("R10 absent step", 8'h18, 8'h00);
        check("R10 absent irq", {31'h0, irq}, 32'h1);
        host_read(8'h14, rd);

        // R9 transfer-information command
        host_write(8'h0C, 8'h10);
        peek("R9 cmd status", 8'h10, 8'h93);
        check("R9 cmd irq", {31'h0, irq}, 32'h1);
        host_read(8'h14, rd);

        // R6 bus reset, unmasked then masked
        host_write(8'h0C, 8'h03);
        peek("R6 reason", 8'h14, 8'h80);
        check("R6 irq", {31'h0, irq}, 32'h1);
        host_read(8'h14, rd);
        host_write(8'h20, 8'h40);
        host_write(8'h0C, 8'h01);
        host_write(8'h0C, 8'h03);
        peek("R6 masked reason", 8'h14, 8'h80);
        check("R6 masked irq", {31'h0, irq}, 32'h0);
        check("R6 masked pending", {31'h0, dma_ctrl[0]}, 32'h0);

        // R12 event in the same cycle as acknowledge
        @(negedge clk); host_rd = 1'b1; host_addr = 8'h14; xfer_done = 1'b1;
        @(negedge clk); host_rd = 1'b0; xfer_done = 1'b0;
        check("R12 pending", {31'h0, dma_ctrl[0]}, 32'h1);
        check("R12 irq", {31'h0, irq}, 32'h1);
        peek("R12 status", 8'h10, 8'h93);

        // R7 chip-reset command
        host_write(8'h0C, 8'h02);
        peek("R7 status", 8'h10, 8'h00);
        peek("R7 user reg", 8'h30, 8'h00);
        peek("R7 masked reg", 8'h2C, 8'h00);
        check("R7 dma", dma_ctrl, 32'hA000_0000);
        check("R7 irq", {31'h0, irq}, 32'h0);
        // config cleared: bus reset interrupts again
        dma_write(24'h000010);
        host_write(8'h0C, 8'h03);
        check("R7 cfg cleared", {31'h0, irq}, 32'h1);

        // R7 reset through the DMA word
        pulse_done();
        host_write(8'h34, 8'h77);
        dma_write(24'h000090);
        check("R7 dma reset word", dma_ctrl, 32'hA000_0000);
        check("R7 dma reset irq", {31'h0, irq}, 32'h0);
        peek("R7 dma reset user", 8'h34, 8'h00);
        peek("R7 dma reset status", 8'h10, 8'h00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule